// File: doc/BRIEF.md
# SPI Identification Page Read Responder

This block is the slave side of a serial memory's identification-page read. A 64-byte page sits in registers outside the block and reaches it as one flat input vector. A bus master lowers chip select and shifts in a command byte and a two-byte address, most significant bit first. If the command matches and the address is legal, the block returns the addressed page byte on the serial output. It keeps returning the following bytes for as long as chip select stays low.

The SPI pins are brought into the system clock domain with two-flop synchronizers and edge detection. The serial clock must therefore run well below the system clock; the bench uses one sixteenth. The bus runs in mode 0: input bits are taken on the rising serial clock edge, and output bits change after the falling edge. Only the command opcode and the zero-address bit are checked. The other upper address bits are ignored. The low six bits set the starting byte, and that pointer advances by one after each byte it sends. A busy input stands for an internal write in progress. When busy is high at the end of the command byte, the block declines the command.

Top module: `idpage_read_spi`

## Requirements
- R1: After reset, and within three system clocks of chip select going high, `miso_oe` is 0.
- R2: When the 8-bit command equals `OPCODE` (default 0x83) and address bit 10 is 0, the first byte driven is the page byte at index address[5:0]. Page byte k is `page_bits[8k+7:8k]`, and bits go out most significant first.
- R3: Address bits 15:11 and 9:6 have no effect on the data returned.
- R4: While chip select stays low, each further byte is the next page index.
- R5: A read may begin at any index 0 to 63 and fetch every byte up to index 63.
- R6: When address bit 10 is 1, `miso_oe` stays 0 until chip select rises.
- R7: When the command byte differs from `OPCODE`, `miso_oe` stays 0 for the whole transaction.
- R8: When `busy` is 1 at the rising serial clock edge that takes the eighth command bit, the command is ignored and `miso_oe` stays 0.
- R9: Raising chip select part-way through a data byte ends the read. The next transaction is decoded from its first bit.
- R10: `miso` changes only after a falling serial clock edge, so each bit holds across the rising edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busy | input | 1 | Internal write in progress; a command is refused while high |
| page_bits | input | 512 | Identification page contents, byte k at bits 8k+7:8k |
| cs_n | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI serial clock, mode 0 |
| mosi | input | 1 | SPI serial data in |
| miso | output | 1 | SPI serial data out |
| miso_oe | output | 1 | Output enable for `miso`; the pad is high impedance while 0 |

## Verification
The hardest case to reach is chip select rising part-way through a data byte. That leaves a partly shifted output byte and an advanced pointer behind. The bench runs a valid command and address, clocks three bits of a data byte, then raises chip select. It confirms the output enable drops. It then starts a fresh read at a different index and checks the block recovered. The busy refusal is reached by holding busy high only across the command byte and dropping it before the address, so an incorrect late sample of busy would show as data.

// File: rtl/idpage_read_spi.sv
module idpage_read_spi #(
  parameter logic [7:0] OPCODE     = 8'h83,
  parameter int         PAGE_BYTES = 64,
  parameter int         ADDR_BITS  = 16,
  parameter int         ZERO_BIT   = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    busy,
  input  logic [PAGE_BYTES*8-1:0] page_bits,
  input  logic                    cs_n,
  input  logic                    sck,
  input  logic                    mosi,
  output logic                    miso,
  output logic                    miso_oe
);
  localparam int AW = $clog2(PAGE_BYTES);
  localparam int CW = $clog2(ADDR_BITS > 8 ? ADDR_BITS : 8);

  typedef enum logic [1:0] {ST_CMD, ST_ADDR, ST_DATA, ST_SILENT} state_t;

  logic [1:0] cs_s, sck_s, mosi_s;
  logic       sck_d;
  state_t     st;
  logic [CW-1:0]        bcnt;
  logic [6:0]           cmd_sh;
  logic [ADDR_BITS-2:0] addr_sh;
  logic [AW-1:0]        ptr;
  logic [2:0]           ocnt;
  logic [7:0]           out_sh;
  logic                 miso_q, oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_s   <= 2'b11;
      sck_s  <= 2'b00;
      mosi_s <= 2'b00;
      sck_d  <= 1'b0;
    end else begin
      cs_s   <= {cs_s[0], cs_n};
      sck_s  <= {sck_s[0], sck};
      mosi_s <= {mosi_s[0], mosi};
      sck_d  <= sck_s[1];
    end
  end

  wire cs_hi    = cs_s[1];
  wire s_mosi   = mosi_s[1];
  wire sck_rise = sck_s[1] & ~sck_d;
  wire sck_fall = ~sck_s[1] & sck_d;

  wire [7:0]    cmd_w  = {cmd_sh, s_mosi};
  wire [AW-1:0] low_w  = {addr_sh[AW-2:0], s_mosi};
  wire          zero_w = addr_sh[ZERO_BIT-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_CMD;
      bcnt    <= '0;
      cmd_sh  <= '0;
      addr_sh <= '0;
      ptr     <= '0;
      ocnt    <= '0;
      out_sh  <= '0;
      miso_q  <= 1'b0;
      oe_q    <= 1'b0;
    end else if (cs_hi) begin
      st   <= ST_CMD;
      bcnt <= '0;
      ocnt <= '0;
      oe_q <= 1'b0;
    end else begin
      if (sck_rise) begin
        case (st)
          ST_CMD: begin
            cmd_sh <= cmd_w[6:0];
            bcnt   <= bcnt + CW'(1);
            if (bcnt == CW'(7)) begin
              bcnt <= '0;
              st   <= (cmd_w == OPCODE && !busy) ? ST_ADDR : ST_SILENT;
            end
          end
          ST_ADDR: begin
            addr_sh <= {addr_sh[ADDR_BITS-3:0], s_mosi};
            bcnt    <= bcnt + CW'(1);
            if (bcnt == CW'(ADDR_BITS-1)) begin
              bcnt <= '0;
              if (zero_w) begin
                st <= ST_SILENT;
              end else begin
                st     <= ST_DATA;
                out_sh <= page_bits[{low_w, 3'b000} +: 8];
                ptr    <= low_w + AW'(1);
                ocnt   <= '0;
              end
            end
          end
          default: ;
        endcase
      end
      if (sck_fall && st == ST_DATA) begin
        miso_q <= out_sh[7];
        oe_q   <= 1'b1;
        ocnt   <= ocnt + 3'd1;
        if (ocnt == 3'd7) begin
          out_sh <= page_bits[{ptr, 3'b000} +: 8];
          ptr    <= ptr + AW'(1);
        end else begin
          out_sh <= {out_sh[6:0], 1'b0};
        end
      end
    end
  end

  assign miso    = miso_q;
  assign miso_oe = oe_q;

  p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_hi |=> !miso_oe);
  p_oe_in_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe |-> st == ST_DATA);
  p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_hi && st == ST_DATA && sck_fall && ocnt == 3'd7) |=> ptr == $past(ptr) + AW'(1));
  p_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_SILENT |-> !miso_oe);
  p_busy_refuse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_hi && st == ST_CMD && sck_rise && bcnt == CW'(7) && busy) |=> st != ST_ADDR);
  p_miso_on_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(miso_q) |-> $past(sck_fall));
endmodule

// File: tb/tb_idpage_read_spi.sv
module tb_idpage_read_spi;
  logic clk = 1'b0, rst_n = 1'b0, busy = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic [511:0] page_bits;
  logic miso, miso_oe;
  int n_chk = 0, n_bad = 0;
  bit oe_any;

  idpage_read_spi dut (.clk(clk), .rst_n(rst_n), .busy(busy), .page_bits(page_bits),
    .cs_n(cs_n), .sck(sck), .mosi(mosi), .miso(miso), .miso_oe(miso_oe));

  always #10 clk = ~clk;

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, input int nbits,
                      output logic [7:0] rx, output logic [7:0] rxh, output bit oe_all);
    rx = '0; rxh = '0; oe_all = 1'b1;
    for (int b = 7; b > 7 - nbits; b--) begin
      mosi = tx[b];
      wclk(8);
      rx[b] = miso;
      if (!miso_oe) oe_all = 1'b0;
      if (miso_oe) oe_any = 1'b1;
      sck = 1'b1;
      wclk(6);
      rxh[b] = miso;
      if (miso_oe) oe_any = 1'b1;
      wclk(2);
      sck = 1'b0;
    end
  endtask

  task automatic header(input logic [7:0] op, input logic [15:0] addr);
    logic [7:0] r, h; bit a;
    cs_n = 1'b0; oe_any = 1'b0;
    wclk(8);
    xfer(op, 8, r, h, a);
    xfer(addr[15:8], 8, r, h, a);
    xfer(addr[7:0], 8, r, h, a);
  endtask

  task automatic finish_cs;
    cs_n = 1'b1;
    wclk(16);
  endtask

  task automatic read_run(input string req, input logic [15:0] addr, input int n);
    logic [7:0] r, h; bit a;
    header(8'h83, addr);
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, 8, r, h, a);
      check({req, " data"}, r, pat(int'(addr[5:0]) + k));
      check("R10 hold", h, pat(int'(addr[5:0]) + k));
      check({req, " oe"}, a, 1);
    end
    finish_cs();
    check("R1 oe after cs", miso_oe, 0);
  endtask

  task automatic t_reset;
    check("R1 reset oe", miso_oe, 0);
  endtask

  task automatic t_basic;
    read_run("R2 R4", 16'h0000, 4);
  endtask

  task automatic t_dontcare;
    read_run("R3", 16'hFBD5, 3);
  endtask

  task automatic t_offset;
    read_run("R5", 16'h003A, 6);
    read_run("R5 last", 16'h003F, 1);
  endtask

  task automatic t_silent(input string req, input logic [7:0] op, input logic [15:0] addr,
                          input bit bsy);
    logic [7:0] r, h; bit a;
    cs_n = 1'b0; oe_any = 1'b0; busy = bsy;
    wclk(8);
    xfer(op, 8, r, h, a);
    busy = 1'b0;
    xfer(addr[15:8], 8, r, h, a);
    xfer(addr[7:0], 8, r, h, a);
    xfer(8'h00, 8, r, h, a);
    xfer(8'h00, 8, r, h, a);
    check({req, " oe never"}, oe_any, 0);
    finish_cs();
  endtask

  task automatic t_abort;
    logic [7:0] r, h; bit a;
    header(8'h83, 16'h0005);
    xfer(8'h00, 8, r, h, a);
    check("R9 first byte", r, pat(5));
    xfer(8'h00, 3, r, h, a);
    check("R9 partial", r[7:5], pat(6) >> 5);
    cs_n = 1'b1;
    wclk(4);
    check("R9 oe drop", miso_oe, 0);
    wclk(12);
    read_run("R9 recover", 16'h0020, 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) page_bits[i*8 +: 8] = pat(i);
    wclk(5);
    rst_n = 1'b1;
    wclk(5);
    t_reset();
    t_basic();
    t_dontcare();
    t_offset();
    t_silent("R6", 8'h83, 16'h0400, 1'b0);
    t_silent("R7", 8'h03, 16'h0000, 1'b0);
    t_silent("R8", 8'h83, 16'h0000, 1'b1);
    t_abort();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule